// File: doc/BRIEF.md
# Mirror Array Block-Load Sequencer

This block orders the loading of a micro-mirror array that is cut into 16 horizontal bands (blocks 0x0 to 0xF, 136 lines of 4096 pixels each, 2176 lines overall). A client hands it one request at a time. Each request carries a block address, an update mode and a load type. The sequencer visits the blocks that the mode groups together, in ascending order. For every enabled block it emits a header carrying the block number and the load type. A normal load then gets one data slot per line. A clear load (all mirrors off) and a set load (all mirrors on) get no data. Once the whole group has been walked, the sequencer fires a single mirror-update pulse with a mask of the blocks it loaded.

The update mode sets the group size: one block, an even-aligned pair, a four-aligned quad, or the whole array. A whole-array update moves every mirror at once, so the block then stays busy for a settle interval of about 8 us, counted in clock cycles from the clock frequency. A per-block enable register decides which blocks are loaded. A request is rejected with a one-cycle error flag in three cases: its group address is misaligned, its group is partly enabled, or its load type is the reserved code.

Top module: `mirror_load_seq`

## Requirements
- R1: After reset, busy, err, hdr_valid, data_valid and upd_pulse are low, and all 16 block enable flags are set.
- R2: A request is accepted when req_valid is high while busy is low. Starting in the cycle after acceptance, each block of the group takes one header cycle. In that cycle hdr_valid is high only if the block is enabled, with hdr_block equal to the block number and hdr_type equal to the load type (Normal=0, Clear=1, Set=2).
- R3: For a Normal load of an enabled block, the header cycle is followed by exactly LINES cycles with data_valid high and data_line counting 0 to LINES-1.
- R4: Clear and Set loads produce no data cycles.
- R5: Mode 0 (Single) accepts any address 0x0 to 0xF and loads only that block.
- R6: Mode 1 (Double) loads blocks a and a+1 for an even address a. Mode 2 (Quad) loads blocks a to a+3 for an address a that is a multiple of 4. In both modes the blocks are visited in ascending order.
- R7: Mode 3 (Global) ignores the address and visits all 16 blocks from 0 to 15.
- R8: upd_pulse is high for one cycle, directly after the last cycle of the last block. upd_mask then holds exactly the blocks that were loaded. If no block in the group is enabled, no pulse occurs.
- R9: After a Global-mode pulse, busy stays high for SETTLE_CYC = CLK_MHZ*SETTLE_NS/1000 further cycles before a new request can be accepted.
- R10: A request is rejected when its load type is 3, or when in Double or Quad mode its address is misaligned or its group is partly enabled. On rejection err is high for one cycle, busy stays low, and no header or pulse occurs.
- R11: req_valid is ignored while busy is high.
- R12: en_we with busy low replaces the enable flags with en_wdata, bit n for block n, from the next cycle on. en_we while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe |
| req_block | input | AW | Block or group base address |
| req_mode | input | 2 | Update mode: 0 single, 1 double, 2 quad, 3 global |
| req_type | input | 2 | Load type: 0 normal, 1 clear, 2 set |
| en_we | input | 1 | Enable flag write strobe |
| en_wdata | input | NBLK | New enable flags, one per block |
| busy | output | 1 | Request in progress or settle running |
| err | output | 1 | One-cycle request rejection flag |
| hdr_valid | output | 1 | Block header present |
| hdr_block | output | AW | Block number of header |
| hdr_type | output | 2 | Load type of header |
| data_valid | output | 1 | Pixel line slot |
| data_line | output | LW | Line index within block |
| upd_pulse | output | 1 | Mirror update pulse |
| upd_mask | output | NBLK | Blocks updated by the pulse |

## Verification
The bench targets the boundaries of the group walk. It drives misaligned Double and Quad bases, partly enabled pairs and quads, and fully disabled groups. A design that checks alignment wrongly would load stray blocks, and one that skips the mixed-enable test would pulse on half a group. Other cases are a Clear or Set load, which must have no data cycles, and a request or enable write issued during a global settle. A design that drops the settle count or acts on those inputs would show busy falling early or loads starting in the wrong cycle. A reference model predicts every output on every clock, so a pulse one cycle late or a wrong mask bit shows up at once.

// File: rtl/mls_pkg.sv
package mls_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_DOUBLE = 2'd1,
        MODE_QUAD   = 2'd2,
        MODE_GLOBAL = 2'd3
    } upd_mode_e;

    typedef enum logic [1:0] {
        LT_NORMAL = 2'd0,
        LT_CLEAR  = 2'd1,
        LT_SET    = 2'd2,
        LT_RSVD   = 2'd3
    } load_type_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BLOCK,
        PH_DATA,
        PH_PULSE,
        PH_SETTLE
    } phase_e;
endpackage

// File: rtl/mls_group_check.sv
// Works out the block range a request covers and whether it must be rejected.
module mls_group_check #(
    parameter int NBLK = 16,
    parameter int AW   = $clog2(NBLK)
) (
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      mode,
    input  logic [1:0]      ltype,
    input  logic [NBLK-1:0] en,
    output logic [AW-1:0]   first,
    output logic [AW-1:0]   last,
    output logic            reject
);
    always_comb begin
        int gsize;
        int base;
        int nen;
        logic grouped;
        case (mode)
            2'd0:    gsize = 1;
            2'd1:    gsize = 2;
            2'd2:    gsize = 4;
            default: gsize = NBLK;
        endcase
        grouped = (mode == 2'd1) || (mode == 2'd2);
        base    = (mode == 2'd3) ? 0 : int'(addr);
        nen     = 0;
        for (int i = 0; i < NBLK; i++) begin
            if (i >= base && i < base + gsize && en[i]) nen++;
        end
        reject = (ltype == 2'd3) ||
                 (grouped && (((base % gsize) != 0) || (nen != 0 && nen != gsize)));
        first  = AW'(base);
        last   = AW'(base + gsize - 1);
    end
endmodule

// File: rtl/mls_enable_bank.sv
// Per-block enable flags; writes land only while the sequencer is idle.
module mls_enable_bank #(
    parameter int NBLK = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NBLK-1:0] wr_data,
    input  logic            allow,
    output logic [NBLK-1:0] en
);
    logic [NBLK-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_en && allow) en_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '1;
        else        en_q <= en_d;
    end

    assign en = en_q;
endmodule

// File: rtl/mirror_load_seq.sv
module mirror_load_seq #(
    parameter int NBLK      = 16,
    parameter int LINES     = 136,
    parameter int CLK_MHZ   = 200,
    parameter int SETTLE_NS = 8000,
    localparam int AW         = $clog2(NBLK),
    localparam int LW         = $clog2(LINES),
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_NS / 1000,
    localparam int SW         = $clog2(SETTLE_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_block,
    input  logic [1:0]      req_mode,
    input  logic [1:0]      req_type,
    input  logic            en_we,
    input  logic [NBLK-1:0] en_wdata,
    output logic            busy,
    output logic            err,
    output logic            hdr_valid,
    output logic [AW-1:0]   hdr_block,
    output logic [1:0]      hdr_type,
    output logic            data_valid,
    output logic [LW-1:0]   data_line,
    output logic            upd_pulse,
    output logic [NBLK-1:0] upd_mask
);
    import mls_pkg::*;

    typedef struct packed {
        phase_e          ph;
        logic [AW-1:0]   cur;
        logic [AW-1:0]   last;
        load_type_e      lt;
        logic            glob;
        logic [NBLK-1:0] mask;
        logic [LW-1:0]   line;
        logic [SW-1:0]   settle;
        logic            err;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_IDLE, cur: '0, last: '0, lt: LT_NORMAL,
                                 glob: 1'b0, mask: '0, line: '0, settle: '0, err: 1'b0};

    seq_t            s_d, s_q;
    logic [NBLK-1:0] en_q;
    logic [AW-1:0]   grp_first, grp_last;
    logic            grp_reject;
    logic            adv;

    mls_group_check #(.NBLK(NBLK), .AW(AW)) u_grp (
        .addr   (req_block),
        .mode   (req_mode),
        .ltype  (req_type),
        .en     (en_q),
        .first  (grp_first),
        .last   (grp_last),
        .reject (grp_reject)
    );

    mls_enable_bank #(.NBLK(NBLK)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (en_we),
        .wr_data (en_wdata),
        .allow   (s_q.ph == PH_IDLE),
        .en      (en_q)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        adv     = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (grp_reject) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.ph   = PH_BLOCK;
                        s_d.cur  = grp_first;
                        s_d.last = grp_last;
                        s_d.lt   = load_type_e'(req_type);
                        s_d.glob = (req_mode == 2'd3);
                        s_d.mask = '0;
                    end
                end
            end
            PH_BLOCK: begin
                if (en_q[s_q.cur]) begin
                    s_d.mask[s_q.cur] = 1'b1;
                    if (s_q.lt == LT_NORMAL) begin
                        s_d.ph   = PH_DATA;
                        s_d.line = '0;
                    end else begin
                        adv = 1'b1;
                    end
                end else begin
                    adv = 1'b1;
                end
            end
            PH_DATA: begin
                if (s_q.line == LW'(LINES - 1)) adv = 1'b1;
                else                            s_d.line = s_q.line + LW'(1);
            end
            PH_PULSE: begin
                if (s_q.glob) begin
                    s_d.ph     = PH_SETTLE;
                    s_d.settle = '0;
                end else begin
                    s_d.ph = PH_IDLE;
                end
            end
            PH_SETTLE: begin
                if (s_q.settle == SW'(SETTLE_CYC - 1)) s_d.ph = PH_IDLE;
                else                                    s_d.settle = s_q.settle + SW'(1);
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (adv) begin
            if (s_q.cur == s_q.last) begin
                s_d.ph = (s_d.mask != '0) ? PH_PULSE : PH_IDLE;
            end else begin
                s_d.cur = s_q.cur + AW'(1);
                s_d.ph  = PH_BLOCK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.ph != PH_IDLE);
    assign err        = s_q.err;
    assign hdr_valid  = (s_q.ph == PH_BLOCK) && en_q[s_q.cur];
    assign hdr_block  = s_q.cur;
    assign hdr_type   = s_q.lt;
    assign data_valid = (s_q.ph == PH_DATA);
    assign data_line  = s_q.line;
    assign upd_pulse  = (s_q.ph == PH_PULSE);
    assign upd_mask   = s_q.mask;

    AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(hdr_valid) && ($past(hdr_type) == 2'd0) && (data_line == '0)); // R3
    AST_DATA_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid && $past(data_valid) |-> data_line == $past(data_line) + LW'(1)); // R3
    AST_NO_DATA_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && (hdr_type != 2'd0) |=> !data_valid); // R4
    AST_PULSE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> (upd_mask != '0) && !$past(upd_pulse)); // R8
    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse && s_q.glob |=> busy && !hdr_valid && !upd_pulse); // R9
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !$past(busy)); // R10
    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_valid |=> !err); // R11
endmodule

// File: tb/mirror_load_seq_tb.sv
module mirror_load_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 16;
    localparam int LN         = 5;
    localparam int MHZ        = 2;
    localparam int SNS        = 8000;
    localparam int SETTLE     = MHZ * SNS / 1000;

    typedef struct {
        bit        hv;
        int        hb;
        int        ht;
        bit        dv;
        int        dl;
        bit        up;
        bit [15:0] um;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_block = '0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_type = '0;
    logic        en_we = 1'b0;
    logic [15:0] en_wdata = '0;
    logic        busy, err, hdr_valid, data_valid, upd_pulse;
    logic [3:0]  hdr_block;
    logic [1:0]  hdr_type;
    logic [2:0]  data_line;
    logic [15:0] upd_mask;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    rec_t exp_q[$];
    bit [15:0] en_m;
    bit   err_m;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mirror_load_seq #(.NBLK(NB), .LINES(LN), .CLK_MHZ(MHZ), .SETTLE_NS(SNS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
        .req_mode(req_mode), .req_type(req_type), .en_we(en_we), .en_wdata(en_wdata),
        .busy(busy), .err(err), .hdr_valid(hdr_valid), .hdr_block(hdr_block),
        .hdr_type(hdr_type), .data_valid(data_valid), .data_line(data_line),
        .upd_pulse(upd_pulse), .upd_mask(upd_mask)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Reference model: expands an accepted request into one record per busy cycle.
    function automatic void model_req(int a, int m, int t);
        int g;
        int base;
        int nen;
        bit [15:0] mask;
        rec_t r;
        g    = (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 4 : 16;
        base = (m == 3) ? 0 : a;
        nen  = 0;
        mask = '0;
        for (int b = base; b < base + g && b < 16; b++) if (en_m[b]) nen++;
        if (t == 3 || ((m == 1 || m == 2) && ((base % g) != 0 || (nen != 0 && nen != g)))) begin
            err_m = 1'b1;
            return;
        end
        for (int b = base; b < base + g; b++) begin
            r = '{default: 0};
            r.hv = en_m[b];
            r.hb = b;
            r.ht = t;
            exp_q.push_back(r);
            if (en_m[b]) begin
                mask[b] = 1'b1;
                if (t == 0) begin
                    for (int l = 0; l < LN; l++) begin
                        r = '{default: 0};
                        r.dv = 1'b1;
                        r.dl = l;
                        exp_q.push_back(r);
                    end
                end
            end
        end
        if (mask != 0) begin
            r = '{default: 0};
            r.up = 1'b1;
            r.um = mask;
            exp_q.push_back(r);
            if (m == 3) begin
                for (int s = 0; s < SETTLE; s++) begin
                    r = '{default: 0};
                    exp_q.push_back(r);
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            en_m  = '1;
            err_m = 1'b0;
        end else begin
            err_m = 1'b0;
            if (exp_q.size() != 0) begin
                void'(exp_q.pop_front());
            end else begin
                if (req_valid) model_req(int'(req_block), int'(req_mode), int'(req_type));
                if (en_we) en_m = en_wdata;
            end
        end
    end

    always @(negedge clk) begin
        rec_t e;
        bit   bb;
        if (rst_n && !done) begin
            bb = (exp_q.size() != 0);
            if (bb) e = exp_q[0];
            else    e = '{default: 0};
            check(busy === bb, "R9 busy", busy, bb);
            check(err === err_m, "R10 err", err, err_m);
            check(hdr_valid === e.hv, "R2 hdr_valid", hdr_valid, e.hv);
            if (e.hv) begin
                check(int'(hdr_block) == e.hb, "R2 hdr_block", hdr_block, e.hb);
                check(int'(hdr_type) == e.ht, "R2 hdr_type", hdr_type, e.ht);
            end
            check(data_valid === e.dv, "R3 data_valid", data_valid, e.dv);
            if (e.dv) check(int'(data_line) == e.dl, "R3 data_line", data_line, e.dl);
            check(upd_pulse === e.up, "R8 upd_pulse", upd_pulse, e.up);
            if (e.up) check(upd_mask === e.um, "R8 upd_mask", upd_mask, e.um);
        end
    end

    task automatic issue(input int a, input int m, input int t);
        @(negedge clk);
        req_valid = 1'b1;
        req_block = 4'(a);
        req_mode  = 2'(m);
        req_type  = 2'(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wen(input bit [15:0] v);
        @(negedge clk);
        en_we    = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset
        check(busy === 1'b0, "R1 busy", busy, 0);
        check(err === 1'b0, "R1 err", err, 0);
        check(hdr_valid === 1'b0, "R1 hdr_valid", hdr_valid, 0);
        check(data_valid === 1'b0, "R1 data_valid", data_valid, 0);
        check(upd_pulse === 1'b0, "R1 upd_pulse", upd_pulse, 0);
        // R1, R7, R9: global normal with reset enables gives a full mask, then settle
        issue(5, 3, 0);
        repeat (10) @(negedge clk);
        issue(2, 0, 0);       // R11: ignored while busy
        wen(16'h0000);        // R12: ignored while busy
        wait_idle();
        issue(5, 0, 0);       // R5: single normal
        wait_idle();
        issue(3, 0, 1);       // R4: single clear
        wait_idle();
        issue(6, 1, 2);       // R6: double set
        wait_idle();
        issue(5, 1, 0);       // R10: double misaligned
        wait_idle();
        issue(8, 2, 0);       // R6: quad normal
        wait_idle();
        issue(6, 2, 1);       // R10: quad misaligned
        wait_idle();
        issue(0, 0, 3);       // R10: reserved type
        wait_idle();
        wen(16'hFDFF);        // R12: disable block 9
        issue(9, 0, 0);       // R8: disabled single, no pulse
        wait_idle();
        issue(8, 2, 0);       // R10: mixed quad
        wait_idle();
        issue(8, 1, 1);       // R10: mixed pair
        wait_idle();
        issue(10, 1, 0);      // R6: double on intact pair
        wait_idle();
        wen(16'h0F0F);
        issue(4, 2, 0);       // R8: fully disabled quad
        wait_idle();
        issue(0, 3, 2);       // R7: global set with partial enables
        wait_idle();
        wen(16'h0000);
        issue(0, 3, 0);       // R8: global with nothing enabled
        wait_idle();
        wen(16'hFFFF);
        issue(12, 3, 1);      // R7: global clear
        wait_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule